// File: doc/BRIEF.md
# Open-Drain One-Wire Reset and Time-Slot Engine

This block drives one open-drain single-wire bus line under command control. A host presents an 8-bit command code, plus a parameter byte for the commands that need one. The engine then either runs a reset cycle with presence detection, or runs a single time slot that writes a bit and reads the line back. It samples the line at fixed points in each cycle and keeps the results in status flags. A busy flag covers the whole operation.

The command input is a valid/ready port. `cmd_ready` is high exactly when the engine is idle. A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high and the code is known. The port does not apply back-pressure by holding the command. A command offered while `cmd_ready` is low is dropped, and `cmd_nak` reports this one cycle later. To retry, the host must offer the command again after busy falls.

The engine drives the line low only through `line_pull_low`. An external pull-up raises the line at all other times. `line_in` is the level read back from the line, and it is taken as already synchronous to `clk`. All timings are given in microseconds and scaled by the clocks-per-microsecond parameter.

Top module: `owire_slot_engine`

## Requirements
- R1: After reset, `busy`, `presence`, `short_det` and `bit_result` are 0, `line_pull_low` is 0, and `cmd_ready` is 1.
- R2: Code 0xB4 offered while idle is accepted. `cmd_ack` pulses in the cycle after acceptance. `line_pull_low` is high for the reset-low time, starting one clock after acceptance, and is then released. `busy` stays high for the reset-low time plus the reset-high time, in cycles.
- R3: In a reset cycle, `short_det` becomes 1 if the line is low at the short-sample point after release, and 0 otherwise. `presence` becomes 1 if the line is low at the presence-sample point after release, and 0 otherwise.
- R4: Code 0x87 starts one slot, and bit 7 of `cmd_param` is the written value. Bits 6 to 0 have no effect. A value of 1 drives the line low for the write-one time and a value of 0 drives it low for the write-zero time. `busy` lasts for the slot time in cycles.
- R5: At the end of a slot, `bit_result` holds the line level sampled at the read-sample point after the slot starts (1 = high).
- R6: A command offered while busy is not acknowledged: `cmd_nak` pulses and `cmd_ack` stays 0. The running operation's line drive and duration are unchanged, and no status flag changes because of the command.
- R7: A code other than 0xB4 or 0x87 is answered with `cmd_nak`, and no operation starts.
- R8: A slot leaves `presence` and `short_det` unchanged, and a reset cycle leaves `bit_result` unchanged.
- R9: Asserting reset during an operation releases the line at once, clears `busy` and all three flags, and raises `cmd_ready`.
- R10: `cmd_ready` is 0 whenever `busy` is 1. A command dropped while busy is not started later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine idle, a command would be taken |
| cmd_code | input | 8 | Command code (0xB4 reset, 0x87 slot) |
| cmd_param | input | 8 | Slot parameter, bit 7 = value to write |
| cmd_ack | output | 1 | One-cycle pulse: command taken |
| cmd_nak | output | 1 | One-cycle pulse: command refused or unknown |
| busy | output | 1 | Operation in progress |
| presence | output | 1 | Presence seen in last reset cycle |
| short_det | output | 1 | Line low at short-sample point of last reset |
| bit_result | output | 1 | Line level read in last slot |
| line_pull_low | output | 1 | Open-drain pull-down enable |
| line_in | input | 1 | Sampled line level |

## Verification
The hardest case to reach from the ports is a command that arrives in the middle of a running operation. It must leave the line drive, the busy length and the flags exactly as they would have been without it. The bench starts a reset cycle and offers a slot command a few cycles in, while the line is still held low. It then measures the total busy and pull-low lengths and checks the result flag after the reset finishes. A modelled responder on the line can answer with a presence pulse, hold the line low throughout to look like a short, or hold the line low during a read slot. This lets both reset sample points and the read sample be driven to either value.

// File: rtl/owire_pkg.sv
package owire_pkg;

  localparam logic [7:0] CMD_LINE_RESET = 8'hB4;
  localparam logic [7:0] CMD_ONE_SLOT   = 8'h87;

  typedef enum logic [1:0] {
    PH_IDLE     = 2'd0,
    PH_RST_LOW  = 2'd1,
    PH_RST_WAIT = 2'd2,
    PH_SLOT     = 2'd3
  } owire_phase_e;

endpackage

// File: rtl/owire_cmd_gate.sv
module owire_cmd_gate
  import owire_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [7:0] cmd_code,
  input  logic [7:0] cmd_param,
  input  logic       busy,
  output logic       cmd_ready,
  output logic       start,
  output logic       start_is_slot,
  output logic       start_wbit,
  output logic       cmd_ack,
  output logic       cmd_nak
);

  logic code_known;

  assign code_known    = (cmd_code == CMD_LINE_RESET) || (cmd_code == CMD_ONE_SLOT);
  assign cmd_ready     = !busy;
  assign start         = cmd_valid && cmd_ready && code_known;
  assign start_is_slot = (cmd_code == CMD_ONE_SLOT);
  assign start_wbit    = cmd_param[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_ack <= 1'b0;
      cmd_nak <= 1'b0;
    end else begin
      cmd_ack <= start;
      cmd_nak <= cmd_valid && !start;
    end
  end

  AST_ACK_WITH_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ack |-> busy); // R2

endmodule

// File: rtl/owire_phase_timer.sv
module owire_phase_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          en,
  output logic [CW-1:0] cnt
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (clr)    cnt <= '0;
    else if (en)     cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/owire_sequencer.sv
module owire_sequencer
  import owire_pkg::*;
#(
  parameter int CW        = 8,
  parameter int RSTL_CYC  = 480,
  parameter int RSTH_CYC  = 480,
  parameter int SHORT_CYC = 8,
  parameter int PRES_CYC  = 70,
  parameter int SLOT_CYC  = 70,
  parameter int W0_CYC    = 60,
  parameter int W1_CYC    = 6,
  parameter int READ_CYC  = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          start_is_slot,
  input  logic          start_wbit,
  input  logic [CW-1:0] cnt,
  output logic          tmr_clr,
  output logic          busy,
  output logic          pull_low,
  output logic          samp_short,
  output logic          samp_pres,
  output logic          samp_bit
);

  localparam logic [CW-1:0] RSTL_LAST = CW'(RSTL_CYC - 1);
  localparam logic [CW-1:0] RSTH_LAST = CW'(RSTH_CYC - 1);
  localparam logic [CW-1:0] SLOT_LAST = CW'(SLOT_CYC - 1);
  localparam logic [CW-1:0] W0_LAST   = CW'(W0_CYC - 1);
  localparam logic [CW-1:0] W1_LAST   = CW'(W1_CYC - 1);
  localparam logic [CW-1:0] SHORT_AT  = CW'(SHORT_CYC);
  localparam logic [CW-1:0] PRES_AT   = CW'(PRES_CYC);
  localparam logic [CW-1:0] READ_AT   = CW'(READ_CYC);

  owire_phase_e phase;
  logic         wbit;
  logic [CW-1:0] low_last;

  assign busy       = (phase != PH_IDLE);
  assign low_last   = wbit ? W1_LAST : W0_LAST;
  assign samp_short = (phase == PH_RST_WAIT) && (cnt == SHORT_AT);
  assign samp_pres  = (phase == PH_RST_WAIT) && (cnt == PRES_AT);
  assign samp_bit   = (phase == PH_SLOT) && (cnt == READ_AT);
  assign tmr_clr    = start || ((phase == PH_RST_LOW) && (cnt == RSTL_LAST));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      pull_low <= 1'b0;
      wbit     <= 1'b0;
    end else begin
      case (phase)
        PH_IDLE: begin
          if (start) begin
            pull_low <= 1'b1;
            wbit     <= start_wbit;
            phase    <= start_is_slot ? PH_SLOT : PH_RST_LOW;
          end
        end
        PH_RST_LOW: begin
          if (cnt == RSTL_LAST) begin
            pull_low <= 1'b0;
            phase    <= PH_RST_WAIT;
          end
        end
        PH_RST_WAIT: begin
          if (cnt == RSTH_LAST) phase <= PH_IDLE;
        end
        PH_SLOT: begin
          if (cnt == low_last)  pull_low <= 1'b0;
          if (cnt == SLOT_LAST) begin
            pull_low <= 1'b0;
            phase    <= PH_IDLE;
          end
        end
        default: begin
          phase    <= PH_IDLE;
          pull_low <= 1'b0;
        end
      endcase
    end
  end

  AST_BUSY_RISE_FROM_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start)); // R2

  AST_PULL_ONLY_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    pull_low |-> busy); // R10

  AST_ONE_RELEASED_AT_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (samp_bit && wbit && (W1_CYC <= READ_CYC)) |-> !pull_low); // R4

endmodule

// File: rtl/owire_status_regs.sv
module owire_status_regs (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  input  logic pull_low,
  input  logic samp_short,
  input  logic samp_pres,
  input  logic samp_bit,
  output logic presence,
  output logic short_det,
  output logic bit_result
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      presence   <= 1'b0;
      short_det  <= 1'b0;
      bit_result <= 1'b0;
    end else begin
      if (samp_short) short_det  <= !line_in;
      if (samp_pres)  presence   <= !line_in;
      if (samp_bit)   bit_result <= line_in;
    end
  end

  AST_RESET_SAMPLES_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (samp_short || samp_pres) |-> !pull_low); // R3

  AST_SAMPLES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({samp_short, samp_pres, samp_bit})); // R8

endmodule

// File: rtl/owire_slot_engine.sv
module owire_slot_engine #(
  parameter int CYC_PER_US   = 200,
  parameter int RST_LOW_US   = 480,
  parameter int RST_HIGH_US  = 480,
  parameter int SHORT_AT_US  = 8,
  parameter int PRES_AT_US   = 70,
  parameter int SLOT_US      = 70,
  parameter int W0_LOW_US    = 60,
  parameter int W1_LOW_US    = 6,
  parameter int READ_AT_US   = 15
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  output logic       cmd_ready,
  input  logic [7:0] cmd_code,
  input  logic [7:0] cmd_param,
  output logic       cmd_ack,
  output logic       cmd_nak,
  output logic       busy,
  output logic       presence,
  output logic       short_det,
  output logic       bit_result,
  output logic       line_pull_low,
  input  logic       line_in
);

  localparam int RSTL_CYC  = RST_LOW_US  * CYC_PER_US;
  localparam int RSTH_CYC  = RST_HIGH_US * CYC_PER_US;
  localparam int SHORT_CYC = SHORT_AT_US * CYC_PER_US;
  localparam int PRES_CYC  = PRES_AT_US  * CYC_PER_US;
  localparam int SLOT_CYC  = SLOT_US     * CYC_PER_US;
  localparam int W0_CYC    = W0_LOW_US   * CYC_PER_US;
  localparam int W1_CYC    = W1_LOW_US   * CYC_PER_US;
  localparam int READ_CYC  = READ_AT_US  * CYC_PER_US;
  localparam int MAX_A     = (RSTL_CYC > RSTH_CYC) ? RSTL_CYC : RSTH_CYC;
  localparam int MAX_CYC   = (MAX_A > SLOT_CYC) ? MAX_A : SLOT_CYC;
  localparam int CW        = $clog2(MAX_CYC + 1);

  logic          start;
  logic          start_is_slot;
  logic          start_wbit;
  logic          tmr_clr;
  logic [CW-1:0] cnt;
  logic          samp_short;
  logic          samp_pres;
  logic          samp_bit;

  owire_cmd_gate u_gate (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmd_valid     (cmd_valid),
    .cmd_code      (cmd_code),
    .cmd_param     (cmd_param),
    .busy          (busy),
    .cmd_ready     (cmd_ready),
    .start         (start),
    .start_is_slot (start_is_slot),
    .start_wbit    (start_wbit),
    .cmd_ack       (cmd_ack),
    .cmd_nak       (cmd_nak)
  );

  owire_phase_timer #(.CW(CW)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (tmr_clr),
    .en    (busy),
    .cnt   (cnt)
  );

  owire_sequencer #(
    .CW        (CW),
    .RSTL_CYC  (RSTL_CYC),
    .RSTH_CYC  (RSTH_CYC),
    .SHORT_CYC (SHORT_CYC),
    .PRES_CYC  (PRES_CYC),
    .SLOT_CYC  (SLOT_CYC),
    .W0_CYC    (W0_CYC),
    .W1_CYC    (W1_CYC),
    .READ_CYC  (READ_CYC)
  ) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (start),
    .start_is_slot (start_is_slot),
    .start_wbit    (start_wbit),
    .cnt           (cnt),
    .tmr_clr       (tmr_clr),
    .busy          (busy),
    .pull_low      (line_pull_low),
    .samp_short    (samp_short),
    .samp_pres     (samp_pres),
    .samp_bit      (samp_bit)
  );

  owire_status_regs u_status (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_in    (line_in),
    .pull_low   (line_pull_low),
    .samp_short (samp_short),
    .samp_pres  (samp_pres),
    .samp_bit   (samp_bit),
    .presence   (presence),
    .short_det  (short_det),
    .bit_result (bit_result)
  );

  AST_READY_LOW_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !cmd_ready); // R10

endmodule

// File: tb/owire_slot_engine_tb.sv
module owire_slot_engine_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic       cmd_ready;
  logic [7:0] cmd_code = 8'h00;
  logic [7:0] cmd_param = 8'h00;
  logic       cmd_ack, cmd_nak, busy, presence, short_det, bit_result;
  logic       line_pull_low, line_in;

  logic [1:0] dev_mode = 2'd0;
  logic       dev_low;
  logic       prev_pull = 1'b0;
  int         rel_cnt = 1000;
  int         st_cnt = 1000;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  owire_slot_engine #(.CYC_PER_US(1)) dut_i (
    .clk (clk), .rst_n (rst_n), .cmd_valid (cmd_valid), .cmd_ready (cmd_ready),
    .cmd_code (cmd_code), .cmd_param (cmd_param), .cmd_ack (cmd_ack), .cmd_nak (cmd_nak),
    .busy (busy), .presence (presence), .short_det (short_det), .bit_result (bit_result),
    .line_pull_low (line_pull_low), .line_in (line_in)
  );

  // Responder model: 1 = presence pulse after release, 2 = line shorted, 3 = holds low in slot
  always_ff @(posedge clk) begin
    prev_pull <= line_pull_low;
    if (prev_pull && !line_pull_low) rel_cnt <= 0;
    else if (rel_cnt < 1000)         rel_cnt <= rel_cnt + 1;
    if (!prev_pull && line_pull_low) st_cnt <= 0;
    else if (st_cnt < 1000)          st_cnt <= st_cnt + 1;
  end

  assign dev_low = (dev_mode == 2'd2) ||
                   (dev_mode == 2'd1 && rel_cnt >= 15 && rel_cnt < 75) ||
                   (dev_mode == 2'd3 && st_cnt < 30);
  assign line_in = !(line_pull_low || dev_low);

  // {code, param, mode, presence, short, result, pull cycles, busy cycles}
  localparam int NV = 9;
  localparam logic [42:0] VEC [NV] = '{
    {8'hB4, 8'h00, 2'd0, 3'b000, 11'd480, 11'd960},
    {8'hB4, 8'h00, 2'd1, 3'b100, 11'd480, 11'd960},
    {8'hB4, 8'h00, 2'd2, 3'b110, 11'd480, 11'd960},
    {8'h87, 8'h80, 2'd0, 3'b111, 11'd6,   11'd70},
    {8'h87, 8'h00, 2'd0, 3'b110, 11'd60,  11'd70},
    {8'h87, 8'hFF, 2'd3, 3'b110, 11'd6,   11'd70},
    {8'h87, 8'h7F, 2'd0, 3'b110, 11'd60,  11'd70},
    {8'h87, 8'h80, 2'd0, 3'b111, 11'd6,   11'd70},
    {8'hB4, 8'h00, 2'd1, 3'b101, 11'd480, 11'd960}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] c, input logic [7:0] p,
                      output logic rdy, output logic ak, output logic nk);
    @(negedge clk);
    cmd_code  = c;
    cmd_param = p;
    cmd_valid = 1'b1;
    rdy = cmd_ready;
    @(negedge clk);
    cmd_valid = 1'b0;
    ak = cmd_ack;
    nk = cmd_nak;
  endtask

  task automatic wait_idle(output int nb, output int nl);
    nb = 0;
    nl = 0;
    while (busy && nb < 3000) begin
      nb++;
      if (line_pull_low) nl++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic rdy, ak, nk;
    int nb, nl, nb2, nl2;
    logic keep_res;

    repeat (3) @(negedge clk);
    // R1 reset state
    chk(busy == 0 && presence == 0 && short_det == 0 && bit_result == 0, "R1", "flags",
        {busy, presence, short_det, bit_result}, 0);
    chk(line_pull_low == 0 && cmd_ready == 1, "R1", "line/ready", {line_pull_low, cmd_ready}, 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      dev_mode = VEC[i][26:25];
      send(VEC[i][42:35], VEC[i][34:27], rdy, ak, nk);
      chk(rdy == 1 && ak == 1 && nk == 0, "R2", "ack", {rdy, ak, nk}, 3'b110);
      wait_idle(nb, nl);
      chk(nb == int'(VEC[i][10:0]), (VEC[i][42:35] == 8'hB4) ? "R2" : "R4", "busy cycles",
          nb, int'(VEC[i][10:0]));
      chk(nl == int'(VEC[i][21:11]), (VEC[i][42:35] == 8'hB4) ? "R2" : "R4", "pull cycles",
          nl, int'(VEC[i][21:11]));
      chk(presence == VEC[i][24] && short_det == VEC[i][23],
          (VEC[i][42:35] == 8'hB4) ? "R3" : "R8", "presence/short",
          {presence, short_det}, VEC[i][24:23]);
      chk(bit_result == VEC[i][22], (VEC[i][42:35] == 8'h87) ? "R5" : "R8", "bit result",
          bit_result, VEC[i][22]);
      dev_mode = 2'd0;
      repeat (3) @(negedge clk);
    end

    // R6 / R10: slot command offered while a reset cycle runs
    keep_res = bit_result;
    send(8'hB4, 8'h00, rdy, ak, nk);
    repeat (4) @(negedge clk);
    send(8'h87, 8'h00, rdy, ak, nk);
    chk(rdy == 0, "R10", "ready while busy", rdy, 0);
    chk(ak == 0 && nk == 1, "R6", "refused ack/nak", {ak, nk}, 2'b01);
    chk(line_pull_low == 1, "R6", "line still low", line_pull_low, 1);
    wait_idle(nb, nl);
    chk(nb + 6 == 960, "R6", "busy length", nb + 6, 960);
    chk(nl + 6 == 480, "R6", "pull length", nl + 6, 480);
    chk(bit_result == keep_res, "R6", "result untouched", bit_result, keep_res);
    repeat (5) @(negedge clk);
    chk(busy == 0 && line_pull_low == 0, "R10", "dropped cmd not started",
        {busy, line_pull_low}, 0);

    // R7: unknown code
    send(8'h3C, 8'h80, rdy, ak, nk);
    chk(ak == 0 && nk == 1, "R7", "unknown ack/nak", {ak, nk}, 2'b01);
    chk(busy == 0 && line_pull_low == 0, "R7", "nothing started", {busy, line_pull_low}, 0);

    // R9: reset during a slot, with flags set beforehand
    send(8'h87, 8'h80, rdy, ak, nk);
    wait_idle(nb2, nl2);
    dev_mode = 2'd1;
    send(8'hB4, 8'h00, rdy, ak, nk);
    wait_idle(nb2, nl2);
    dev_mode = 2'd0;
    chk(presence == 1 && bit_result == 1, "R9", "flags set before reset",
        {presence, bit_result}, 2'b11);
    send(8'h87, 8'h80, rdy, ak, nk);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(line_pull_low == 0 && busy == 0 && cmd_ready == 1, "R9", "line/busy/ready",
        {line_pull_low, busy, cmd_ready}, 3'b001);
    chk(presence == 0 && short_det == 0 && bit_result == 0, "R9", "flags cleared",
        {presence, short_det, bit_result}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule